// File: doc/BRIEF.md
# Two-Stage Rotating Load-Balanced Switch Core

This block is an N-port cell switch with no arbiter. It is built from two crossbar stages that use fixed rotating connections, with buffering between them. A free-running slot counter sets both stages. In slot `t`, external input `i` is wired to intermediate port `(i + t) mod N`. In the same slot, intermediate port `m` is wired to external output `(m + t) mod N`. Over any N consecutive slots, every input therefore meets every intermediate port once, and every intermediate port meets every output once.

Each intermediate port holds one FIFO per final output. A cell that enters through the first stage is written into the queue named by its destination. The second stage reads, at each intermediate port, only the queue of the output that port is wired to in that slot. Each port moves at most one cell per slot per stage, so no internal path runs faster than a port.

Both data edges use valid/ready handshakes. A cell moves on a rising clock edge where valid and ready are both high.
- Input side: `in_ready` depends on `in_dest` and on the current slot, and never on `in_valid`. Because the wiring changes every slot, a source is free to change or withdraw a refused offer; it does not have to hold it.
- Output side: `out_valid` may fall without a handshake when the slot moves on. A cell refused by a low `out_ready` stays at the head of its queue and is offered again N slots later.

Top module: `vlb_switch_core`

## Requirements
- R1: While reset is held, and at the first sampling point after its release, `slot` is 0, `out_valid` is all zero, `q_full` is all zero and `in_ready` is all ones.
- R2: `slot` goes up by one on each clock edge and wraps from N-1 to 0.
- R3: A cell accepted on input `i` in slot `t` with destination `d` is stored in queue `d` of intermediate port `(i + t) mod N`. It later leaves on output `d` with its data unchanged.
- R4: In slot `t`, output `o` shows the head of queue `o` at intermediate port `(o - t) mod N`. `out_valid[o]` is 1 exactly when that queue is non-empty. All other outputs show no cell that came from an empty queue.
- R5: Cells in one queue leave in the order they were accepted, even when they came from different inputs.
- R6: `in_ready[i]` is low when the target queue (destination `in_dest[i]` at the intermediate port reached in that slot) is full. An offer made while `in_ready` is low is not stored and never appears at any output.
- R7: A cell offered with `out_ready` low is not removed from its queue. It is offered again with the same data the next time its queue is wired to that output.
- R8: A cell never leaves in the slot in which it was accepted. When its queue is wired to its own output in that slot, it leaves N slots later.
- R9: `q_full[m*N + d]` is 1 exactly when queue `d` of intermediate port `m` holds DEPTH cells.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | N | Per-input cell offer |
| in_ready | output | N | Per-input acceptance: target queue has room |
| in_data | input | N*W | Per-input cell payload |
| in_dest | input | N*PW | Per-input destination output number, PW = clog2(N) |
| out_valid | output | N | Per-output cell present |
| out_ready | input | N | Per-output sink can take the cell |
| out_data | output | N*W | Per-output cell payload |
| slot | output | PW | Current slot number, 0 to N-1 |
| q_full | output | N*N | Queue full flags, bit m*N+d for port m, destination d |

## Verification
The checker assumes that every `in_dest` value is below N. It also assumes that `out_ready` is an ordinary input free to change every cycle, and that a source may drop an offer that was refused. With those assumptions, the number of cells handed out can never exceed the number taken in, and the number held inside can never exceed N*N*DEPTH.

The stimulus uses N = 4, so every destination is in range. It drives inputs only at the falling edge and deliberately withdraws a refused cell after one cycle. It holds one output not-ready for a full rotation so that the retry path is exercised.

// File: rtl/vlb_pkg.sv
package vlb_pkg;
  // Modular add of two port numbers, both below n.
  function automatic int rot_add(int a, int b, int n);
    return (a + b) % n;
  endfunction

  // Modular subtract a - b of two port numbers, both below n.
  function automatic int rot_sub(int a, int b, int n);
    return (a + n - b) % n;
  endfunction
endpackage

// File: rtl/vlb_slot_ctr.sv
module vlb_slot_ctr #(
  parameter int N = 4,
  localparam int PW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [PW-1:0] slot
);
  localparam logic [PW-1:0] LAST = PW'(N - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) slot <= '0;
    else if (slot == LAST) slot <= '0;
    else slot <= slot + 1'b1;
  end
endmodule

// File: rtl/vlb_rot_xbar.sv
// Rotating permutation. FWD=1: dst[j] = src[(j - slot) mod N]
//                       FWD=0: dst[j] = src[(j + slot) mod N]
module vlb_rot_xbar #(
  parameter int N   = 4,
  parameter int BW  = 8,
  parameter bit FWD = 1'b1,
  localparam int PW = $clog2(N)
) (
  input  logic [N-1:0][BW-1:0] src,
  input  logic [PW-1:0]        slot,
  output logic [N-1:0][BW-1:0] dst
);
  import vlb_pkg::*;

  generate
    if (FWD) begin : g_fwd
      always_comb begin
        for (int j = 0; j < N; j++) begin
          dst[j] = src[PW'(rot_sub(j, int'(slot), N))];
        end
      end
    end else begin : g_rev
      always_comb begin
        for (int j = 0; j < N; j++) begin
          dst[j] = src[PW'(rot_add(j, int'(slot), N))];
        end
      end
    end
  endgenerate
endmodule

// File: rtl/vlb_cell_fifo.sv
module vlb_cell_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);
  localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);
  localparam logic [AW:0]   CNT_MAX  = (AW + 1)'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [AW:0]   count;
  logic          do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = (count == CNT_MAX);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == PTR_LAST) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/vlb_mid_port.sv
// Intermediate port: one FIFO per final output.
module vlb_mid_port #(
  parameter int N     = 4,
  parameter int W     = 8,
  parameter int DEPTH = 4,
  localparam int PW   = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_valid,
  input  logic [PW-1:0] push_dest,
  input  logic [W-1:0]  push_data,
  output logic          accept,
  input  logic [PW-1:0] pop_sel,
  input  logic          pop_req,
  output logic          head_valid,
  output logic [W-1:0]  head_data,
  output logic [N-1:0]  full
);
  logic [N-1:0]        q_empty;
  logic [N-1:0][W-1:0] q_head;
  logic [N-1:0]        q_push, q_pop;

  assign accept = !full[push_dest];

  generate
    for (genvar q = 0; q < N; q++) begin : g_q
      assign q_push[q] = push_valid && accept && (push_dest == PW'(q));
      assign q_pop[q]  = pop_req && (pop_sel == PW'(q)) && !q_empty[q];

      vlb_cell_fifo #(.W(W), .DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (q_push[q]),
        .push_data (push_data),
        .pop       (q_pop[q]),
        .head      (q_head[q]),
        .empty     (q_empty[q]),
        .full      (full[q])
      );
    end
  endgenerate

  assign head_valid = !q_empty[pop_sel];
  assign head_data  = q_head[pop_sel];
endmodule

// File: rtl/vlb_switch_core.sv
module vlb_switch_core #(
  parameter int N     = 4,
  parameter int W     = 8,
  parameter int DEPTH = 4,
  localparam int PW   = $clog2(N)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [N-1:0]          in_valid,
  output logic [N-1:0]          in_ready,
  input  logic [N-1:0][W-1:0]   in_data,
  input  logic [N-1:0][PW-1:0]  in_dest,
  output logic [N-1:0]          out_valid,
  input  logic [N-1:0]          out_ready,
  output logic [N-1:0][W-1:0]   out_data,
  output logic [PW-1:0]         slot,
  output logic [N*N-1:0]        q_full
);
  import vlb_pkg::*;

  localparam int S1W = 1 + PW + W;  // {valid, dest, data}
  localparam int S2W = 1 + W;       // {valid, data}

  logic [N-1:0][S1W-1:0] s1_src, s1_mid;
  logic [N-1:0][0:0]     acc_mid, acc_in;
  logic [N-1:0][0:0]     rdy_out, rdy_mid;
  logic [N-1:0][S2W-1:0] s2_mid, s2_out;
  logic [N-1:0][PW-1:0]  pop_sel;

  vlb_slot_ctr #(.N(N)) u_slot (
    .clk   (clk),
    .rst_n (rst_n),
    .slot  (slot)
  );

  always_comb begin
    for (int i = 0; i < N; i++) begin
      s1_src[i]  = {in_valid[i], in_dest[i], in_data[i]};
      in_ready[i] = acc_in[i][0];
      rdy_out[i] = out_ready[i];
      out_valid[i] = s2_out[i][S2W-1];
      out_data[i]  = s2_out[i][W-1:0];
    end
  end

  // Stage 1: input i -> intermediate (i + slot) mod N
  vlb_rot_xbar #(.N(N), .BW(S1W), .FWD(1'b1)) u_s1 (
    .src (s1_src),
    .slot(slot),
    .dst (s1_mid)
  );

  // Acceptance travels back to the input wired to each intermediate port
  vlb_rot_xbar #(.N(N), .BW(1), .FWD(1'b0)) u_s1_ack (
    .src (acc_mid),
    .slot(slot),
    .dst (acc_in)
  );

  // Output readiness travels back to the intermediate port wired to it
  vlb_rot_xbar #(.N(N), .BW(1), .FWD(1'b0)) u_s2_ack (
    .src (rdy_out),
    .slot(slot),
    .dst (rdy_mid)
  );

  generate
    for (genvar m = 0; m < N; m++) begin : g_mid
      logic          hv;
      logic [W-1:0]  hd;
      logic          acc;

      assign pop_sel[m] = PW'(rot_add(m, int'(slot), N));
      assign acc_mid[m] = acc;
      assign s2_mid[m]  = {hv, hd};

      vlb_mid_port #(.N(N), .W(W), .DEPTH(DEPTH)) u_mid (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_valid (s1_mid[m][S1W-1]),
        .push_dest  (s1_mid[m][W +: PW]),
        .push_data  (s1_mid[m][W-1:0]),
        .accept     (acc),
        .pop_sel    (pop_sel[m]),
        .pop_req    (rdy_mid[m][0]),
        .head_valid (hv),
        .head_data  (hd),
        .full       (q_full[m*N +: N])
      );
    end
  endgenerate

  // Stage 2: intermediate m -> output (m + slot) mod N
  vlb_rot_xbar #(.N(N), .BW(S2W), .FWD(1'b1)) u_s2 (
    .src (s2_mid),
    .slot(slot),
    .dst (s2_out)
  );
endmodule

// File: rtl/vlb_switch_chk.sv
module vlb_switch_chk #(
  parameter int N     = 4,
  parameter int W     = 8,
  parameter int DEPTH = 4,
  localparam int PW   = $clog2(N)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [N-1:0]         in_valid,
  input logic [N-1:0]         in_ready,
  input logic [N-1:0]         out_valid,
  input logic [N-1:0]         out_ready,
  input logic [PW-1:0]        slot,
  input logic [N*N-1:0]       q_full
);
  localparam logic [31:0]   CAP  = 32'(N * N * DEPTH);
  localparam logic [PW-1:0] LAST = PW'(N - 1);

  logic [31:0] n_in, n_out;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      n_in  <= '0;
      n_out <= '0;
    end else begin
      n_in  <= n_in  + 32'($countones(in_valid & in_ready));
      n_out <= n_out + 32'($countones(out_valid & out_ready));
    end
  end

  assert_slot_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (slot == LAST) |=> (slot == '0));
  assert_slot_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (slot != LAST) |=> (slot == $past(slot) + 1'b1));
  assert_no_phantom_R4: assert property (@(posedge clk) disable iff (!rst_n)
    n_out <= n_in);
  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (n_in - n_out) <= CAP);

  generate
    for (genvar k = 0; k < N*N; k++) begin : g_q
      assert_full_needs_push_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q_full[k]) |-> $past(|(in_valid & in_ready)));
      assert_full_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!(|out_ready) && q_full[k]) |=> q_full[k]);
    end
  endgenerate
endmodule

bind vlb_switch_core vlb_switch_chk #(.N(N), .W(W), .DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .slot      (slot),
  .q_full    (q_full)
);

// File: tb/test_vlb_switch_core.sv
module test_vlb_switch_core;
  localparam int N     = 4;
  localparam int W     = 8;
  localparam int DEPTH = 4;
  localparam int PW    = 2;
  localparam time CLK_PERIOD = 10ns;

  logic                 clk = 1'b0;
  logic                 rst_n;
  logic [N-1:0]         in_valid;
  logic [N-1:0]         in_ready;
  logic [N-1:0][W-1:0]  in_data;
  logic [N-1:0][PW-1:0] in_dest;
  logic [N-1:0]         out_valid;
  logic [N-1:0]         out_ready;
  logic [N-1:0][W-1:0]  out_data;
  logic [PW-1:0]        slot;
  logic [N*N-1:0]       q_full;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vlb_switch_core #(.N(N), .W(W), .DEPTH(DEPTH)) i_vlb_switch_core (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_dest(in_dest),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .slot(slot), .q_full(q_full)
  );

  // src, dst, start slot, payload, expected delay in slots (from R3/R4/R8)
  typedef struct packed {
    logic [1:0] src;
    logic [1:0] dst;
    logic [1:0] t0;
    logic [7:0] data;
    logic [2:0] dly;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{2'd0, 2'd0, 2'd0, 8'hA1, 3'd4},
    '{2'd0, 2'd1, 2'd0, 8'hA2, 3'd1},
    '{2'd1, 2'd3, 2'd0, 8'hA3, 3'd2},
    '{2'd2, 2'd0, 2'd1, 8'hA4, 3'd4},
    '{2'd3, 2'd2, 2'd2, 8'hA5, 3'd3},
    '{2'd1, 2'd2, 2'd3, 8'hA6, 3'd3},
    '{2'd2, 2'd3, 2'd1, 8'hA7, 3'd3},
    '{2'd3, 2'd0, 2'd3, 8'hA8, 3'd3}
  };

  task automatic check(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wait_slot(int t);
    while (int'(slot) != t) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=complete");
      finish_run();
    end
  end

  initial begin
    rst_n     = 1'b0;
    in_valid  = '0;
    in_data   = '0;
    in_dest   = '0;
    out_ready = '1;
    repeat (3) @(negedge clk);
    check("R1", "slot in reset", int'(slot), 0);
    check("R1", "out_valid in reset", int'(out_valid), 0);
    rst_n = 1'b1;
    check("R1", "q_full after reset", int'(q_full), 0);
    check("R1", "in_ready after reset", int'(in_ready), 4'hF);

    // R2: counting and wrap
    for (int c = 0; c < 6; c++) begin
      check("R2", "slot sequence", int'(slot), c % N);
      @(negedge clk);
    end

    // Vector table: single cells, R3/R4/R8
    for (int v = 0; v < 8; v++) begin
      wait_slot(int'(VEC[v].t0));
      in_valid[VEC[v].src] = 1'b1;
      in_dest[VEC[v].src]  = VEC[v].dst;
      in_data[VEC[v].src]  = VEC[v].data;
      check("R6", "in_ready with room", int'(in_ready[VEC[v].src]), 1);
      check("R8", "no departure in arrival slot", int'(out_valid), 0);
      @(negedge clk);
      in_valid = '0;
      for (int k = 1; k <= N; k++) begin
        check("R4", "out_valid pattern", int'(out_valid),
              (k == int'(VEC[v].dly)) ? (1 << VEC[v].dst) : 0);
        if (k == int'(VEC[v].dly))
          check("R3", "delivered data", int'(out_data[VEC[v].dst]), int'(VEC[v].data));
        @(negedge clk);
      end
    end

    // Fill queue 2 at intermediate port 0 from four inputs, output 2 stalled
    wait_slot(0);
    out_ready = 4'b1011;
    for (int s = 0; s < N; s++) begin
      in_valid[(N - s) % N] = 1'b1;
      in_dest[(N - s) % N]  = 2'd2;
      in_data[(N - s) % N]  = 8'(8'h10 + s);
      check("R6", "in_ready while filling", int'(in_ready[(N - s) % N]), 1);
      if (s == 2) begin
        check("R7", "stalled cell offered", int'(out_valid[2]), 1);
        check("R7", "stalled cell data", int'(out_data[2]), 8'h10);
      end
      @(negedge clk);
      in_valid = '0;
    end
    check("R9", "only queue m0/d2 full", int'(q_full), 16'h0004);

    // Offer to the full queue: refused and withdrawn; neighbour still open
    in_valid[0] = 1'b1;
    in_dest[0]  = 2'd2;
    in_data[0]  = 8'h99;
    in_dest[1]  = 2'd2;
    check("R6", "in_ready at full queue", int'(in_ready[0]), 0);
    check("R6", "in_ready at other port", int'(in_ready[1]), 1);
    @(negedge clk);
    in_valid  = '0;
    out_ready = '1;

    // Drain: order kept, stalled head retried
    wait_slot(2);
    check("R7", "retried cell present", int'(out_valid[2]), 1);
    check("R5", "first out", int'(out_data[2]), 8'h10);
    @(negedge clk);
    check("R9", "not full after one pop", int'(q_full), 0);
    for (int k = 1; k < DEPTH; k++) begin
      repeat (N - 1) @(negedge clk);
      check("R5", "ordered out valid", int'(out_valid[2]), 1);
      check("R5", "ordered out data", int'(out_data[2]), 8'h10 + k);
      @(negedge clk);
    end
    for (int k = 0; k < 2 * N; k++) begin
      check("R6", "refused cell never appears", int'(out_valid), 0);
      @(negedge clk);
    end

    done = 1'b1;
    finish_run();
  end
endmodule